// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This block gathers the interrupt causes of a 16550-style serial port, ranks them by a fixed priority and presents one encoded identification nibble together with an interrupt request line. It sits beside the receive and transmit paths and sees only their status: the receive FIFO fill level, a trigger-level selector, line error events, the transmit holding register empty flag, a half-character idle tick, and strobes for FIFO pushes, FIFO pops, holding register writes and reads of the identification and line status registers.

Four causes are tracked. Each has its own way of being cleared. A line error stays pending until software reads the line status register. Data available follows the FIFO level against the selected trigger. The character timeout fires after a stretch of receive idleness while bytes remain in the FIFO, and a pop clears it. The holding-empty cause is cleared by a holding register write or by an identification read that reported it. Both outputs come from registers. Every input therefore takes effect at the next clock edge.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset, ident_o is 4'b0001 and irq_o is 0. Bit 0 of ident_o is 0 exactly when irq_o is 1.
- R2: Enable bit 0 gates the data-available and timeout causes. Enable bit 1 gates holding-empty. Enable bit 2 gates line status. A disabled cause never appears in ident_o and never drives irq_o, but its pending state is kept.
- R3: When several enabled causes are pending, ident_o[3:1] reports the highest one. The order from highest to lowest is line status, data available, character timeout, holding empty.
- R4: A line error event makes line status pending. The pending state is reported as ident_o[3:1] = 3 (ident_o = 4'h6). An LSR read clears it. An event in the same cycle as the read wins.
- R5: Data available is pending while rx_level_i is greater than or equal to the trigger level. It is reported as ident_o[3:1] = 2 (4'h4) and disappears when the level falls below the trigger.
- R6: trig_sel_i selects the trigger level: 0 gives 1 byte, 1 gives 4, 2 gives 8 and 3 gives 14.
- R7: Consider a cycle with the FIFO non-empty, no push and no pop. Each half_char_tick_i in such a cycle advances an idle count. When the count reaches TO_TICKS (default 8, i.e. 4 character times), the timeout becomes pending. It is reported as ident_o[3:1] = 6 (4'hC). An empty FIFO clears both the count and the pending state.
- R8: A push or a pop restarts the idle count. A pop also clears a pending timeout. A push does not clear it.
- R9: Holding-empty becomes pending on a rising edge of thr_empty_i. It is reported as ident_o[3:1] = 1 (4'h2). Three things clear it: a holding register write, an ident read while ident_o shows 4'h2, or thr_empty_i going low. A rising edge in the same cycle as a clear wins.
- R10: ident_o and irq_o are registered. They reflect the inputs and the pending state of the cycle before the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_en_i | input | 3 | Cause enables: bit 0 data/timeout, bit 1 holding empty, bit 2 line status |
| rx_level_i | input | LVL_W | Receive FIFO fill level in bytes |
| trig_sel_i | input | 2 | Trigger level select (1/4/8/14 bytes) |
| line_err_i | input | 1 | Pulse: overrun, parity, framing or break seen |
| thr_empty_i | input | 1 | Transmit holding register empty |
| thr_wr_i | input | 1 | Pulse: holding register written |
| half_char_tick_i | input | 1 | Pulse every half character time |
| rx_push_i | input | 1 | Pulse: byte written into receive FIFO |
| rx_pop_i | input | 1 | Pulse: byte read from receive FIFO |
| ident_rd_i | input | 1 | Pulse: identification register read |
| lsr_rd_i | input | 1 | Pulse: line status register read |
| ident_o | output | 4 | Bit 0 active-low pending flag, bits 3:1 cause code |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
Any fault in a pending flag, in the idle count or in the priority ranking appears on ident_o and irq_o one clock after the input that should have caused it, because both outputs are registers fed from next-state logic. A wrong idle count shows up as a 4'hC code that comes a tick early or late relative to the timeout threshold. A lost or stuck line-status or holding-empty flag shows as the wrong code after a read strobe. The bench keeps an independent model of all four causes and compares both outputs on every clock. It therefore detects a wrong state in the cycle where it first reaches the ports.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  typedef enum logic [2:0] {
    CAUSE_NONE = 3'd0,
    CAUSE_THRE = 3'd1,
    CAUSE_RDA  = 3'd2,
    CAUSE_LS   = 3'd3,
    CAUSE_CTO  = 3'd6
  } cause_e;

  function automatic int unsigned trig_bytes(input logic [1:0] sel);
    case (sel)
      2'd0:    trig_bytes = 1;
      2'd1:    trig_bytes = 4;
      2'd2:    trig_bytes = 8;
      default: trig_bytes = 14;
    endcase
  endfunction

endpackage

// File: rtl/irq_thre_src.sv
module irq_thre_src (
  input  logic clk,
  input  logic rst,
  input  logic thr_empty_i,
  input  logic thr_wr_i,
  input  logic ident_rd_i,
  input  logic shown_i,
  output logic pend_nxt_o
);
  logic empty_q, pend_q;
  logic rise;

  assign rise = thr_empty_i & ~empty_q;

  always_comb begin
    if (rise)
      pend_nxt_o = 1'b1;
    else if (thr_wr_i || (ident_rd_i && shown_i) || !thr_empty_i)
      pend_nxt_o = 1'b0;
    else
      pend_nxt_o = pend_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      empty_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      empty_q <= thr_empty_i;
      pend_q  <= pend_nxt_o;
    end
  end

  p_thre_write_r9: assert property (@(posedge clk) disable iff (rst)
    (thr_wr_i && !(thr_empty_i && !empty_q)) |=> !pend_q);
  p_thre_rise_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(thr_empty_i) |=> pend_q);
endmodule

// File: rtl/irq_cto_src.sv
module irq_cto_src #(
  parameter int LVL_W    = 5,
  parameter int TO_TICKS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] rx_level_i,
  input  logic             rx_push_i,
  input  logic             rx_pop_i,
  input  logic             tick_i,
  output logic             pend_nxt_o
);
  localparam int CNT_W = $clog2(TO_TICKS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TO_TICKS - 1);

  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             pend_q;

  always_comb begin
    cnt_nxt    = cnt_q;
    pend_nxt_o = pend_q;
    if (rx_level_i == '0) begin
      cnt_nxt    = '0;
      pend_nxt_o = 1'b0;
    end else if (rx_push_i || rx_pop_i) begin
      cnt_nxt = '0;
      if (rx_pop_i) pend_nxt_o = 1'b0;
    end else if (pend_q) begin
      cnt_nxt = '0;
    end else if (tick_i) begin
      if (cnt_q == LAST) begin
        cnt_nxt    = '0;
        pend_nxt_o = 1'b1;
      end else begin
        cnt_nxt = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_nxt;
      pend_q <= pend_nxt_o;
    end
  end

  p_cto_empty_r7: assert property (@(posedge clk) disable iff (rst)
    (rx_level_i == '0) |=> (!pend_q && cnt_q == '0));
  p_cto_pop_r8: assert property (@(posedge clk) disable iff (rst)
    rx_pop_i |=> !pend_q);
  p_cto_bound_r7: assert property (@(posedge clk) disable iff (rst)
    cnt_q < CNT_W'(TO_TICKS));
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import uart_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] en_i,
  input  logic       ls_i,
  input  logic       rda_i,
  input  logic       cto_i,
  input  logic       thre_i,
  output logic [3:0] ident_o,
  output logic       irq_o
);
  logic   ls_v, rda_v, cto_v, thre_v, any_v;
  cause_e cause;

  assign ls_v   = ls_i   & en_i[2];
  assign rda_v  = rda_i  & en_i[0];
  assign cto_v  = cto_i  & en_i[0];
  assign thre_v = thre_i & en_i[1];
  assign any_v  = ls_v | rda_v | cto_v | thre_v;

  always_comb begin
    if (ls_v)        cause = CAUSE_LS;
    else if (rda_v)  cause = CAUSE_RDA;
    else if (cto_v)  cause = CAUSE_CTO;
    else if (thre_v) cause = CAUSE_THRE;
    else             cause = CAUSE_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ident_o <= 4'b0001;
      irq_o   <= 1'b0;
    end else begin
      ident_o <= {cause, ~any_v};
      irq_o   <= any_v;
    end
  end

  p_ls_first_r3: assert property (@(posedge clk) disable iff (rst)
    ls_v |=> (ident_o == 4'h6));
  p_masked_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (en_i == 3'b000) |=> (!irq_o && ident_o == 4'h1));
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int LVL_W    = 5,
  parameter int TO_TICKS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       irq_en_i,
  input  logic [LVL_W-1:0] rx_level_i,
  input  logic [1:0]       trig_sel_i,
  input  logic             line_err_i,
  input  logic             thr_empty_i,
  input  logic             thr_wr_i,
  input  logic             half_char_tick_i,
  input  logic             rx_push_i,
  input  logic             rx_pop_i,
  input  logic             ident_rd_i,
  input  logic             lsr_rd_i,
  output logic [3:0]       ident_o,
  output logic             irq_o
);
  logic ls_q, ls_nxt, rda, cto_nxt, thre_nxt;

  always_comb begin
    if (line_err_i)    ls_nxt = 1'b1;
    else if (lsr_rd_i) ls_nxt = 1'b0;
    else               ls_nxt = ls_q;
  end

  always_ff @(posedge clk) begin
    if (rst) ls_q <= 1'b0;
    else     ls_q <= ls_nxt;
  end

  assign rda = (int'(rx_level_i) >= int'(trig_bytes(trig_sel_i)));

  irq_cto_src #(.LVL_W(LVL_W), .TO_TICKS(TO_TICKS)) u_cto (
    .clk        (clk),
    .rst        (rst),
    .rx_level_i (rx_level_i),
    .rx_push_i  (rx_push_i),
    .rx_pop_i   (rx_pop_i),
    .tick_i     (half_char_tick_i),
    .pend_nxt_o (cto_nxt)
  );

  irq_thre_src u_thre (
    .clk         (clk),
    .rst         (rst),
    .thr_empty_i (thr_empty_i),
    .thr_wr_i    (thr_wr_i),
    .ident_rd_i  (ident_rd_i),
    .shown_i     (ident_o == 4'h2),
    .pend_nxt_o  (thre_nxt)
  );

  irq_prio_enc u_enc (
    .clk     (clk),
    .rst     (rst),
    .en_i    (irq_en_i),
    .ls_i    (ls_nxt),
    .rda_i   (rda),
    .cto_i   (cto_nxt),
    .thre_i  (thre_nxt),
    .ident_o (ident_o),
    .irq_o   (irq_o)
  );

  p_ls_set_r4: assert property (@(posedge clk) disable iff (rst)
    line_err_i |=> ls_q);
  p_ls_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (lsr_rd_i && !line_err_i) |=> !ls_q);
  p_flag_match_r1: assert property (@(posedge clk) disable iff (rst)
    ##1 (irq_o != ident_o[0]));
endmodule

// File: tb/uart_irq_ident_tb_top.sv
module uart_irq_ident_tb_top;
  localparam int LVL_W = 5;
  localparam int TO_TICKS = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] en = 3'b111;
  logic [LVL_W-1:0] lvl = '0;
  logic [1:0] tsel = 2'd0;
  logic lerr = 0, thr_e = 0, thr_w = 0, tick = 0, push = 0, pop = 0, irdd = 0, lrd = 0;
  logic [3:0] ident;
  logic irq;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_irq_ident #(.LVL_W(LVL_W), .TO_TICKS(TO_TICKS)) dut_i (
    .clk(clk), .rst(rst), .irq_en_i(en), .rx_level_i(lvl), .trig_sel_i(tsel),
    .line_err_i(lerr), .thr_empty_i(thr_e), .thr_wr_i(thr_w),
    .half_char_tick_i(tick), .rx_push_i(push), .rx_pop_i(pop),
    .ident_rd_i(irdd), .lsr_rd_i(lrd), .ident_o(ident), .irq_o(irq));

  // behavioural reference model
  bit m_ls, m_cto, m_thre, m_prev;
  int m_cnt;
  logic [3:0] m_id = 4'h1;
  bit m_irq;

  function automatic int trig_of(input logic [1:0] s);
    int t[4] = '{1, 4, 8, 14};
    return t[s];
  endfunction

  function automatic string req_of(input logic [3:0] id);
    case (id[3:1])
      3'd3: return "R4";
      3'd2: return "R5";
      3'd6: return "R7";
      3'd1: return "R9";
      default: return "R1";
    endcase
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_ls = 0; m_cto = 0; m_thre = 0; m_prev = 0; m_cnt = 0;
      m_id = 4'h1; m_irq = 0;
    end else begin
      bit rise, rda, a_ls, a_rda, a_cto, a_thre;
      // R4 line status
      if (lerr) m_ls = 1; else if (lrd) m_ls = 0;
      // R7 / R8 timeout
      if (lvl == 0) begin m_cnt = 0; m_cto = 0; end
      else if (push || pop) begin m_cnt = 0; if (pop) m_cto = 0; end
      else if (!m_cto && tick) begin
        m_cnt++;
        if (m_cnt == TO_TICKS) begin m_cto = 1; m_cnt = 0; end
      end
      // R9 holding empty
      rise = thr_e && !m_prev;
      if (rise) m_thre = 1;
      else if (thr_w || (irdd && m_id == 4'h2) || !thr_e) m_thre = 0;
      m_prev = thr_e;
      // R5 / R6
      rda = (int'(lvl) >= trig_of(tsel));
      // R2 gating, R3 priority
      a_ls = m_ls && en[2]; a_rda = rda && en[0];
      a_cto = m_cto && en[0]; a_thre = m_thre && en[1];
      m_irq = a_ls || a_rda || a_cto || a_thre;
      if (a_ls) m_id = 4'h6;
      else if (a_rda) m_id = 4'h4;
      else if (a_cto) m_id = 4'hC;
      else if (a_thre) m_id = 4'h2;
      else m_id = 4'h1;
    end
    #1;
    if (!done) begin
      // R10: registered outputs compared one edge after the inputs
      checks++;
      if (ident !== m_id || irq !== m_irq) begin
        errors++;
        $display("FAIL %s (R10 cycle %0d): ident=%h irq=%b expected ident=%h irq=%b",
                 req_of(m_id), cycles, ident, irq, m_id, m_irq);
      end
    end
  end

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      lerr = 0; thr_w = 0; tick = 0; push = 0; pop = 0; irdd = 0; lrd = 0;
    end
  endtask

  task automatic expect_id(input logic [3:0] e, input string req);
    checks++;
    if (ident !== e) begin
      errors++;
      $display("FAIL %s: ident=%h expected %h", req, ident, e);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    finish_run();
  end

  initial begin
    step(3);
    rst = 0;
    step(1);
    expect_id(4'h1, "R1 reset");
    // R4 line status set and clear
    lerr = 1; step(1); expect_id(4'h6, "R4 set");
    step(2); expect_id(4'h6, "R4 hold");
    lrd = 1; lerr = 1; step(1); expect_id(4'h6, "R4 set wins");
    lrd = 1; step(1); expect_id(4'h1, "R4 clear");
    // R5 / R6 trigger levels
    for (int s = 0; s < 4; s++) begin
      tsel = 2'(s);
      lvl = LVL_W'(trig_of(2'(s)) - 1); step(1);
      expect_id((s == 0) ? 4'h1 : 4'h1, "R6 below trigger");
      lvl = LVL_W'(trig_of(2'(s))); step(1); expect_id(4'h4, "R6 at trigger");
    end
    lvl = 0; step(1);
    // R7 timeout: trigger 14, one byte held
    tsel = 2'd3; lvl = 1; push = 1; step(1);
    for (int i = 0; i < TO_TICKS - 1; i++) begin tick = 1; step(2); end
    expect_id(4'h1, "R7 before threshold");
    tick = 1; step(1); expect_id(4'hC, "R7 threshold");
    push = 1; lvl = 2; step(1); expect_id(4'hC, "R8 push keeps");
    pop = 1; step(1); expect_id(4'h1, "R8 pop clears");
    for (int i = 0; i < TO_TICKS - 1; i++) begin tick = 1; step(1); end
    pop = 1; step(1);
    for (int i = 0; i < TO_TICKS - 1; i++) begin tick = 1; step(1); end
    expect_id(4'h1, "R8 restart");
    tick = 1; step(1); expect_id(4'hC, "R8 after restart");
    lvl = 0; step(1); expect_id(4'h1, "R7 empty clears");
    // R9 holding empty
    thr_e = 1; step(1); expect_id(4'h2, "R9 rise");
    irdd = 1; step(1); expect_id(4'h1, "R9 ident read");
    thr_e = 0; step(1); thr_e = 1; step(1);
    thr_w = 1; thr_e = 0; step(1); expect_id(4'h1, "R9 write");
    thr_e = 1; step(1);
    // R2 gating and R3 priority
    en = 3'b010; lerr = 1; lvl = 14; step(1); expect_id(4'h2, "R2 masked");
    en = 3'b111; step(1); expect_id(4'h6, "R3 ls first");
    lrd = 1; step(1); expect_id(4'h4, "R3 rda next");
    en = 3'b011; lerr = 1; step(1); expect_id(4'h4, "R2 ls masked");
    en = 3'b000; step(1); expect_id(4'h1, "R2 all masked");
    en = 3'b111; step(1); expect_id(4'h6, "R2 pending kept");
    lrd = 1; lvl = 0; thr_e = 0; step(2);
    // randomized mix, compared on every clock by the model
    for (int i = 0; i < 4000; i++) begin
      en = 3'($urandom); tsel = 2'($urandom);
      if ($urandom_range(0, 7) == 0) lvl = LVL_W'($urandom_range(0, 16));
      lerr = ($urandom_range(0, 31) == 0); lrd = ($urandom_range(0, 15) == 0);
      if ($urandom_range(0, 15) == 0) thr_e = ~thr_e;
      thr_w = ($urandom_range(0, 15) == 0); irdd = ($urandom_range(0, 7) == 0);
      tick = ($urandom_range(0, 1) == 0);
      push = ($urandom_range(0, 40) == 0); pop = ($urandom_range(0, 40) == 0);
      @(negedge clk);
      lerr = 0; thr_w = 0; tick = 0; push = 0; pop = 0; irdd = 0; lrd = 0;
    end
    step(2);
    finish_run();
  end
endmodule